// File: doc/BRIEF.md
# 2D Rectangle Fill and Copy Engine

This block draws axis-aligned rectangles into a linear frame buffer. A host programs it with 32-bit register writes. Every write first goes into a 32-entry command queue, and the engine consumes the queue strictly in order. Writing the launch register starts an operation. That operation is either a solid fill with a foreground colour or a screen-to-screen copy, and either one can run with a plain-copy or an XOR raster operation. Pixels can be 8, 16 or 32 bits deep.

The engine moves through the rectangle one row at a time. It issues pixel reads and writes on a simple request/grant memory port. Each copy axis has its own command bit that reverses its stepping direction. In a reversed axis the supplied coordinates name the far edge, so a copy whose source and destination overlap still gives the right picture. A status word reports the number of free queue slots, a busy flag and a sticky overflow flag. The host decides the engine is idle only after the busy flag has read clear on three polls in a row. A launch with the NOP command gives the host a simple way to drain the queue.

Top module: `rect_blit_engine`

## Requirements
- R1: Register writes are queued in a 32-entry FIFO and take effect in arrival order; an operation already running is not affected by later writes. status[4:0] reports the number of free slots, saturated at 31.
- R2: A write that arrives while the FIFO is full is discarded and sets status[10]. That flag stays set until reset.
- R3: status[9] (busy) is 1 while the FIFO holds entries or an operation is running, and 0 otherwise.
- R4: Register offsets on reg_addr are: 0 format, 1 colour, 2 command, 3 size, 4 destination XY, 5 launch, 6 base address. Size holds width in bits 15:0 and height in bits 31:16. XY holds X in bits 15:0 and Y in bits 31:16.
- R5: Format bits 12:0 hold the line stride in bytes. Bits 18:13 hold the depth code: 8 means 1 byte per pixel, 24 means 2, 40 means 4, and any other value means 1. Pixel address = base + y*stride + x*bytes. The pixel sits in the low bytes of mem_wdata and mem_rdata. mem_size is 0, 1 or 2 for 1, 2 or 4 bytes.
- R6: Command bits 3:0 = 5 selects a fill, and the launch data is the destination XY. With the copy operation, every pixel of the width x height rectangle receives the colour, one write per granted cycle.
- R7: Command bits 3:0 = 1 selects a copy. The launch data is the source XY and the destination comes from the destination XY register.
- R8: Command bit 14 steps X from right to left and bit 15 steps Y from bottom to top. When a bit is set, the matching coordinates name the last column or last row. An overlapping copy gives the same result as copying from an unchanged source.
- R9: Command bits 31:24 hold the raster operation: 0xCC is copy and 0x66 is XOR. A fill with XOR makes each destination pixel destination ^ colour, and a copy with XOR makes it destination ^ source. Any other code acts as copy.
- R10: A launch with zero width, zero height or command bits 3:0 = 0 (NOP) finishes without any memory access.
- R11: mem_req, mem_we, mem_addr and mem_wdata hold steady until mem_gnt. Read data is taken from mem_rdata in the cycle after a granted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| status | output | 32 | Free slots [4:0], busy [9], overflow [10] |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 2 | Access size code |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, one cycle after grant |

## Verification
A register write becomes visible in the status word one cycle after the edge that captures it: the free count drops and busy rises. The bench therefore reads status at the falling edge after each write. A fill with the copy operation needs one write per granted cycle. A copy or XOR pixel adds one request per read and one cycle per read to capture the data that returns in the cycle after the grant. Because these gaps depend on a random grant pattern, the bench does not count cycles. It polls busy until three clear reads in a row, then compares the whole memory model with a reference computed from a snapshot, and compares the number of granted accesses with the number the rectangle size requires.

// File: rtl/blit_pkg.sv
`timescale 1ns/1ps
package blit_pkg;
  localparam logic [2:0] RA_FMT   = 3'd0;
  localparam logic [2:0] RA_COLOR = 3'd1;
  localparam logic [2:0] RA_CMD   = 3'd2;
  localparam logic [2:0] RA_SIZE  = 3'd3;
  localparam logic [2:0] RA_DXY   = 3'd4;
  localparam logic [2:0] RA_GO    = 3'd5;
  localparam logic [2:0] RA_BASE  = 3'd6;

  localparam logic [3:0] OP_NOP  = 4'd0;
  localparam logic [3:0] OP_COPY = 4'd1;
  localparam logic [3:0] OP_FILL = 4'd5;

  localparam logic [7:0] ROP_SRC = 8'hCC;
  localparam logic [7:0] ROP_XOR = 8'h66;

  typedef struct packed {
    logic [2:0]  addr;
    logic [31:0] data;
  } reg_wr_t;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RS   = 3'd1,
    S_RSW  = 3'd2,
    S_RD   = 3'd3,
    S_RDW  = 3'd4,
    S_WR   = 3'd5
  } eng_st_e;

  function automatic logic [1:0] depth_to_size(input logic [5:0] code);
    case (code)
      6'd24:   return 2'd1;
      6'd40:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/blit_cmd_fifo.sv
`timescale 1ns/1ps
module blit_cmd_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 35
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q];
  assign count   = cnt_q;

  always_comb begin
    wp_d  = do_push ? step(wp_q) : wp_q;
    rp_d  = do_pop  ? step(rp_q) : rp_q;
    cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  // R1
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R1
  fifo_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop) |=> (cnt_q == CW'($past(cnt_q) + 1)));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/blit_pix_addr.sv
`timescale 1ns/1ps
module blit_pix_addr #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 13
) (
  input  logic [AW-1:0] base,
  input  logic [SW-1:0] stride,
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] y,
  input  logic [1:0]    size,
  output logic [AW-1:0] addr
);
  localparam int PW = CW + SW;
  logic [PW-1:0] row_off;
  logic [CW+1:0] col_off;

  assign row_off = PW'(y) * PW'(stride);
  assign col_off = (CW+2)'(x) << size;
  assign addr    = base + AW'(row_off) + AW'(col_off);
endmodule

// File: rtl/rect_blit_engine.sv
`timescale 1ns/1ps
module rect_blit_engine
  import blit_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int ADDR_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       status,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic [31:0]       mem_rdata
);
  localparam int CNT_W    = $clog2(FIFO_DEPTH+1);
  localparam int CW       = 16;
  localparam int SW       = 13;
  localparam int RW       = 32;
  localparam int ENT_W    = $bits(reg_wr_t);
  localparam int FREE_MAX = 31;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  reg_wr_t          ent, head;
  logic [ENT_W-1:0] head_raw;
  logic             fifo_empty, fifo_full, pop;
  logic [CNT_W-1:0] fifo_cnt, free_cnt;

  assign ent  = '{addr: reg_addr, data: reg_wdata};
  assign head = reg_wr_t'(head_raw);

  blit_cmd_fifo #(.DEPTH(FIFO_DEPTH), .W(ENT_W)) u_fifo (
    .clk(clk), .rst_n(rst_i_n), .push(reg_wr), .din(ENT_W'(ent)), .pop(pop),
    .dout(head_raw), .empty(fifo_empty), .full(fifo_full), .count(fifo_cnt)
  );

  eng_st_e       st_q, st_d, first_st;
  logic [SW-1:0] stride_q, stride_d;
  logic [1:0]    psize_q, psize_d;
  logic [RW-1:0] color_q, color_d, dxy_q, dxy_d, base_q, base_d;
  logic [RW-1:0] src_q, src_d, dst_q, dst_d, sv, res;
  logic [7:0]    rop_q, rop_d;
  logic [3:0]    op_q, op_d;
  logic          xrev_q, xrev_d, yrev_q, yrev_d, ovf_q, ovf_d;
  logic [CW-1:0] w_q, w_d, h_q, h_d, cx_q, cx_d, cy_q, cy_d;
  logic [CW-1:0] odx_q, odx_d, ody_q, ody_d, osx_q, osx_d, osy_q, osy_d;
  logic [CW-1:0] cur_dx, cur_dy, cur_sx, cur_sy;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic          is_xor, is_fill, last_px, zero_sz, busy;

  assign is_xor  = (rop_q == ROP_XOR);
  assign is_fill = (op_q == OP_FILL);
  assign zero_sz = (w_q == '0) || (h_q == '0);
  assign last_px = (cx_q == w_q - CW'(1)) && (cy_q == h_q - CW'(1));
  assign first_st = is_fill ? (is_xor ? S_RD : S_WR) : S_RS;

  assign cur_dx = xrev_q ? odx_q - cx_q : odx_q + cx_q;
  assign cur_sx = xrev_q ? osx_q - cx_q : osx_q + cx_q;
  assign cur_dy = yrev_q ? ody_q - cy_q : ody_q + cy_q;
  assign cur_sy = yrev_q ? osy_q - cy_q : osy_q + cy_q;

  blit_pix_addr #(.AW(ADDR_W), .CW(CW), .SW(SW)) u_src_addr (
    .base(ADDR_W'(base_q)), .stride(stride_q), .x(cur_sx), .y(cur_sy),
    .size(psize_q), .addr(src_addr)
  );
  blit_pix_addr #(.AW(ADDR_W), .CW(CW), .SW(SW)) u_dst_addr (
    .base(ADDR_W'(base_q)), .stride(stride_q), .x(cur_dx), .y(cur_dy),
    .size(psize_q), .addr(dst_addr)
  );

  // memory port
  assign mem_req  = (st_q == S_RS) || (st_q == S_RD) || (st_q == S_WR);
  assign mem_we   = (st_q == S_WR);
  assign mem_size = psize_q;
  assign mem_addr = (st_q == S_RS) ? src_addr : dst_addr;

  always_comb begin
    sv  = is_fill ? color_q : src_q;
    res = is_xor ? (sv ^ dst_q) : sv;
    case (psize_q)
      2'd0:    mem_wdata = {24'h0, res[7:0]};
      2'd1:    mem_wdata = {16'h0, res[15:0]};
      default: mem_wdata = res;
    endcase
  end

  // status word
  assign free_cnt = CNT_W'(FIFO_DEPTH) - fifo_cnt;
  assign busy     = !fifo_empty || (st_q != S_IDLE);
  always_comb begin
    status      = '0;
    status[4:0] = (32'(free_cnt) > FREE_MAX) ? 5'd31 : 5'(free_cnt);
    status[9]   = busy;
    status[10]  = ovf_q;
  end

  // next state
  always_comb begin
    st_d = st_q;     stride_d = stride_q; psize_d = psize_q;
    color_d = color_q; dxy_d = dxy_q;     base_d = base_q;
    rop_d = rop_q;   op_d = op_q;         xrev_d = xrev_q; yrev_d = yrev_q;
    w_d = w_q;       h_d = h_q;           cx_d = cx_q;     cy_d = cy_q;
    odx_d = odx_q;   ody_d = ody_q;       osx_d = osx_q;   osy_d = osy_q;
    src_d = src_q;   dst_d = dst_q;
    ovf_d = ovf_q | (reg_wr & fifo_full);
    pop   = 1'b0;
    case (st_q)
      S_IDLE: if (!fifo_empty) begin
        pop = 1'b1;
        case (head.addr)
          RA_FMT: begin
            stride_d = head.data[SW-1:0];
            psize_d  = depth_to_size(head.data[18:13]);
          end
          RA_COLOR: color_d = head.data;
          RA_CMD: begin
            op_d   = head.data[3:0];
            xrev_d = head.data[14];
            yrev_d = head.data[15];
            rop_d  = head.data[31:24];
          end
          RA_SIZE: begin
            w_d = head.data[15:0];
            h_d = head.data[31:16];
          end
          RA_DXY:  dxy_d  = head.data;
          RA_BASE: base_d = head.data;
          RA_GO: begin
            cx_d  = '0;
            cy_d  = '0;
            osx_d = head.data[15:0];
            osy_d = head.data[31:16];
            odx_d = is_fill ? head.data[15:0]  : dxy_q[15:0];
            ody_d = is_fill ? head.data[31:16] : dxy_q[31:16];
            if (!zero_sz && (is_fill || op_q == OP_COPY)) st_d = first_st;
          end
          default: ;
        endcase
      end
      S_RS:  if (mem_gnt) st_d = S_RSW;
      S_RSW: begin
        src_d = mem_rdata;
        st_d  = is_xor ? S_RD : S_WR;
      end
      S_RD:  if (mem_gnt) st_d = S_RDW;
      S_RDW: begin
        dst_d = mem_rdata;
        st_d  = S_WR;
      end
      S_WR: if (mem_gnt) begin
        if (last_px) begin
          st_d = S_IDLE;
        end else begin
          if (cx_q == w_q - CW'(1)) begin
            cx_d = '0;
            cy_d = cy_q + CW'(1);
          end else begin
            cx_d = cx_q + CW'(1);
          end
          st_d = first_st;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q <= S_IDLE;  stride_q <= '0; psize_q <= '0;
      color_q <= '0;   dxy_q <= '0;    base_q <= '0;
      rop_q <= '0;     op_q <= '0;     xrev_q <= 1'b0; yrev_q <= 1'b0;
      w_q <= '0;       h_q <= '0;      cx_q <= '0;     cy_q <= '0;
      odx_q <= '0;     ody_q <= '0;    osx_q <= '0;    osy_q <= '0;
      src_q <= '0;     dst_q <= '0;    ovf_q <= 1'b0;
    end else begin
      st_q <= st_d;    stride_q <= stride_d; psize_q <= psize_d;
      color_q <= color_d; dxy_q <= dxy_d; base_q <= base_d;
      rop_q <= rop_d;  op_q <= op_d;   xrev_q <= xrev_d; yrev_q <= yrev_d;
      w_q <= w_d;      h_q <= h_d;     cx_q <= cx_d;   cy_q <= cy_d;
      odx_q <= odx_d;  ody_q <= ody_d; osx_q <= osx_d; osy_q <= osy_d;
      src_q <= src_d;  dst_q <= dst_d; ovf_q <= ovf_d;
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  // R2
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    status[10] |=> status[10]);

  // R10
  zero_size_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pop && head.addr == RA_GO && zero_sz) |=> !mem_req);
endmodule

// File: tb/tb_rect_blit_engine.sv
`timescale 1ns/1ps
module tb_rect_blit_engine;
  localparam int MEM_B = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] status;
  logic        mem_req, mem_we, mem_gnt;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  rect_blit_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .status(status), .mem_req(mem_req), .mem_we(mem_we),
    .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  int acc_cnt = 0;
  int hold_err = 0;
  logic stall = 1'b0;
  logic rnd = 1'b0;
  logic pre_go = 1'b0;
  logic [7:0] pre_seed = '0;
  logic [7:0] lfsr;
  logic [7:0] mem_b [MEM_B];
  logic [7:0] snap  [MEM_B];
  logic [7:0] expm  [MEM_B];

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  // memory model and grant generator
  always @(posedge clk) begin
    if (!rst_n) lfsr <= 8'h5B;
    else        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_gnt <= stall ? 1'b0 : (rnd ? lfsr[0] : 1'b1);
    if (pre_go) begin
      for (int i = 0; i < MEM_B; i++) mem_b[i] <= 8'(i * 13 + int'(pre_seed) * 7 + (i >> 4));
    end else if (mem_req && mem_gnt) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) begin
        for (int i = 0; i < 4; i++)
          if (i < nbytes(mem_size)) mem_b[(int'(mem_addr[11:0]) + i) % MEM_B] <= mem_wdata[8*i +: 8];
      end else begin
        for (int i = 0; i < 4; i++)
          mem_rdata[8*i +: 8] <= mem_b[(int'(mem_addr[11:0]) + i) % MEM_B];
      end
    end
  end

  // request hold monitor (R11)
  logic        prev_wait = 1'b0;
  logic [31:0] prev_addr = '0;
  always @(negedge clk) begin
    if (prev_wait && !(mem_req && mem_addr == prev_addr)) hold_err++;
    prev_wait = rst_n && mem_req && !mem_gnt;
    prev_addr = mem_addr;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int clr = 0;
    int n = 0;
    while (clr < 3 && n < 20000) begin
      @(negedge clk);
      n++;
      if (status[9]) clr = 0; else clr++;
    end
    if (clr < 3) begin
      n_chk++; n_fail++;
      $display("FAIL %s idle wait actual=busy expected=idle", req);
    end
  endtask

  task automatic preload(input logic [7:0] seed);
    @(negedge clk); pre_seed = seed; pre_go = 1'b1;
    @(negedge clk); pre_go = 1'b0;
    for (int i = 0; i < MEM_B; i++) begin snap[i] = mem_b[i]; expm[i] = mem_b[i]; end
  endtask

  function automatic int pa(int base, int stride, int nb, int x, int y);
    return (base + y * stride + x * nb) % MEM_B;
  endfunction

  function automatic logic [31:0] sget(int a, int nb);
    logic [31:0] v = '0;
    for (int i = 0; i < nb; i++) v[8*i +: 8] = snap[(a + i) % MEM_B];
    return v;
  endfunction

  task automatic eset(int a, int nb, logic [31:0] v);
    for (int i = 0; i < nb; i++) expm[(a + i) % MEM_B] = v[8*i +: 8];
  endtask

  task automatic ref_fill(int base, int stride, int nb, int x, int y, int w, int h,
                          logic [31:0] c, bit xr);
    for (int r = 0; r < h; r++)
      for (int k = 0; k < w; k++) begin
        int a = pa(base, stride, nb, x + k, y + r);
        eset(a, nb, xr ? (sget(a, nb) ^ c) : c);
      end
  endtask

  task automatic ref_copy(int base, int stride, int nb, int sx, int sy, int dx, int dy,
                          int w, int h, bit xr);
    for (int r = 0; r < h; r++)
      for (int k = 0; k < w; k++) begin
        int sa = pa(base, stride, nb, sx + k, sy + r);
        int da = pa(base, stride, nb, dx + k, dy + r);
        eset(da, nb, xr ? (sget(sa, nb) ^ sget(da, nb)) : sget(sa, nb));
      end
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0;
    for (int i = 0; i < MEM_B; i++) if (mem_b[i] !== expm[i]) bad++;
    chk(req, 32'(bad), 32'd0);
  endtask

  function automatic logic [31:0] fmt(int stride, int nb);
    int code = (nb == 1) ? 8 : (nb == 2) ? 24 : 40;
    return 32'(stride) | (32'(code) << 13);
  endfunction

  function automatic logic [31:0] mkcmd(logic [7:0] rop, bit yr, bit xr, logic [3:0] op);
    return {rop, 8'h00, yr, xr, 10'h000, op};
  endfunction

  function automatic logic [31:0] xy(int x, int y);
    return {16'(y), 16'(x)};
  endfunction

  task automatic setup(logic [31:0] f, int base, logic [31:0] col, logic [31:0] cmd,
                       int w, int h, logic [31:0] dxy);
    wr(3'd0, f); wr(3'd6, 32'(base)); wr(3'd1, col); wr(3'd2, cmd);
    wr(3'd3, xy(w, h)); wr(3'd4, dxy);
  endtask

  task automatic t_reset;
    chk("R1 reset free", 32'(status[4:0]), 32'd31);
    chk("R3 reset busy", 32'(status[9]), 32'd0);
    chk("R2 reset overflow", 32'(status[10]), 32'd0);
    chk("R11 reset request", 32'(mem_req), 32'd0);
  endtask

  task automatic t_fill8;
    int a0;
    rnd = 1'b0; preload(8'd1);
    setup(fmt(64, 1), 'h100, 32'h0000_005A, mkcmd(8'hCC, 0, 0, 4'd5), 4, 3, xy(0, 0));
    a0 = acc_cnt;
    wr(3'd5, xy(2, 1));
    chk("R3 busy after launch", 32'(status[9]), 32'd1);
    wait_idle("R6");
    ref_fill('h100, 64, 1, 2, 1, 4, 3, 32'h5A, 0);
    cmp_mem("R6 fill 8bpp image");
    chk("R4 fill access count", 32'(acc_cnt - a0), 32'd12);
  endtask

  task automatic t_fill16_xor;
    int a0;
    rnd = 1'b1; preload(8'd2);
    setup(fmt(80, 2), 'h400, 32'h1234_F00F, mkcmd(8'h66, 0, 0, 4'd5), 3, 2, xy(0, 0));
    a0 = acc_cnt;
    wr(3'd5, xy(5, 4));
    wait_idle("R9");
    ref_fill('h400, 80, 2, 5, 4, 3, 2, 32'h1234_F00F, 1);
    cmp_mem("R5 xor fill 16bpp image");
    chk("R9 xor fill access count", 32'(acc_cnt - a0), 32'd12);
  endtask

  task automatic t_copy32;
    rnd = 1'b1; preload(8'd3);
    setup(fmt(128, 4), 0, 32'h0, mkcmd(8'hCC, 0, 0, 4'd1), 4, 3, xy(10, 12));
    wr(3'd5, xy(1, 2));
    wait_idle("R7");
    ref_copy(0, 128, 4, 1, 2, 10, 12, 4, 3, 0);
    cmp_mem("R7 copy 32bpp image");
  endtask

  task automatic t_copy_ovl_x;
    rnd = 1'b1; preload(8'd4);
    setup(fmt(64, 1), 'h200, 32'h0, mkcmd(8'hCC, 0, 1, 4'd1), 6, 2, xy(10, 1));
    wr(3'd5, xy(8, 1));
    wait_idle("R8");
    ref_copy('h200, 64, 1, 3, 1, 5, 1, 6, 2, 0);
    cmp_mem("R8 overlap copy right-to-left");
  endtask

  task automatic t_copy_ovl_y;
    rnd = 1'b0; preload(8'd5);
    setup(fmt(64, 1), 'h200, 32'h0, mkcmd(8'hCC, 1, 0, 4'd1), 5, 4, xy(2, 7));
    wr(3'd5, xy(2, 6));
    wait_idle("R8");
    ref_copy('h200, 64, 1, 2, 3, 2, 4, 5, 4, 0);
    cmp_mem("R8 overlap copy bottom-to-top");
  endtask

  task automatic t_copy_xor_and_other;
    rnd = 1'b1; preload(8'd6);
    setup(fmt(32, 1), 'h600, 32'h0, mkcmd(8'h66, 0, 0, 4'd1), 3, 3, xy(20, 10));
    wr(3'd5, xy(1, 1));
    wait_idle("R9");
    ref_copy('h600, 32, 1, 1, 1, 20, 10, 3, 3, 1);
    cmp_mem("R9 xor copy image");
    preload(8'd7);
    setup(fmt(32, 1), 'h600, 32'h0000_00C3, mkcmd(8'h00, 0, 0, 4'd5), 2, 2, xy(0, 0));
    wr(3'd5, xy(4, 4));
    wait_idle("R9");
    ref_fill('h600, 32, 1, 4, 4, 2, 2, 32'hC3, 0);
    cmp_mem("R9 unknown rop acts as copy");
  endtask

  task automatic t_zero_nop;
    int a0;
    rnd = 1'b0; preload(8'd8);
    a0 = acc_cnt;
    setup(fmt(64, 1), 'h100, 32'h11, mkcmd(8'hCC, 0, 0, 4'd5), 0, 3, xy(0, 0));
    wr(3'd5, xy(1, 1));
    setup(fmt(64, 1), 'h100, 32'h11, mkcmd(8'hCC, 0, 0, 4'd5), 3, 0, xy(0, 0));
    wr(3'd5, xy(1, 1));
    wait_idle("R10");
    chk("R10 zero size accesses", 32'(acc_cnt - a0), 32'd0);
    wr(3'd2, mkcmd(8'hCC, 0, 0, 4'd0));
    wr(3'd3, xy(4, 4));
    wr(3'd5, xy(1, 1));
    wait_idle("R10");
    chk("R10 nop accesses", 32'(acc_cnt - a0), 32'd0);
    cmp_mem("R10 memory untouched");
  endtask

  task automatic t_fifo;
    rnd = 1'b0; stall = 1'b1; preload(8'd9);
    setup(fmt(64, 1), 'h800, 32'h0000_00A1, mkcmd(8'hCC, 0, 0, 4'd5), 4, 1, xy(0, 0));
    wr(3'd5, xy(0, 0));
    repeat (4) @(negedge clk);
    chk("R1 drained free", 32'(status[4:0]), 32'd31);
    for (int i = 0; i < 3; i++) wr(3'd1, 32'h40 + 32'(i));
    chk("R1 free after three", 32'(status[4:0]), 32'd29);
    for (int i = 3; i < 32; i++) wr(3'd1, 32'h40 + 32'(i));
    chk("R1 free when full", 32'(status[4:0]), 32'd0);
    chk("R2 no overflow yet", 32'(status[10]), 32'd0);
    wr(3'd1, 32'h0000_00EE);
    chk("R2 overflow set", 32'(status[10]), 32'd1);
    @(negedge clk); stall = 1'b0;
    wait_idle("R2");
    chk("R2 overflow sticky", 32'(status[10]), 32'd1);
    wr(3'd3, xy(1, 1));
    wr(3'd5, xy(10, 0));
    wait_idle("R2");
    chk("R1 running fill keeps its colour", 32'(mem_b['h803]), 32'hA1);
    chk("R2 dropped write left colour", 32'(mem_b['h80A]), 32'h5F);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fill8();
    t_fill16_xor();
    t_copy32();
    t_copy_ovl_x();
    t_copy_ovl_y();
    t_copy_xor_and_other();
    t_zero_nop();
    t_fifo();
    chk("R11 request held until grant", 32'(hold_err), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule